// File: doc/BRIEF.md
# C-bit Loopback Command Detector Bank

This block watches the control-bit triplets (C1, C2, C3) that 28 lower-rate multiplex framers hand up once per frame, one framer per tributary port. Each port has its own detector that recognises a far-end line loopback request. The request is coded as C1 equal to C2, with C3 the complement of both. A port's status bit turns on only after five consecutive matching frames. It turns off only after five consecutive non-matching frames, so a single corrupted frame moves the status in neither direction.

The 28 real-time status bits are presented as two 16-bit read-only words. The bits are not latched. They are also ORed into one summary bit, and a mask input gates that summary onto an active-low interrupt line. In the two framing modes where the loopback code has no meaning, all reported bits are forced to zero. The detectors keep running in those modes, so the true state appears as soon as the multiplex mode returns.

Top module: `cbit_lb_detect_bank`

## Requirements
- R1: A frame matches when C1 equals C2 and C3 differs from C1; the patterns (1,1,0) and (0,0,1) match, and any frame with C1 different from C2 is non-matching.
- R2: A port's status bit becomes 1 at the clock edge that samples that port's fifth consecutive matching frame strobe, and stays 0 after only four.
- R3: A non-matching frame restarts the set run, so four matches, one non-match and four more matches leave the status at 0.
- R4: A set status bit becomes 0 at the edge that samples the fifth consecutive non-matching frame; one matching frame inside that run restarts it.
- R5: Counters and status change only on the port's own frame strobe; C-bit values presented while the strobe is low have no effect.
- R6: Port k (0-based) for k = 0..15 is bit k of `stat_lo`; port k for k = 16..27 is bit k-16 of `stat_hi`; bits 15:12 of `stat_hi` read 0.
- R7: `mode` 2'b00 is the multiplex mode, in which status is reported. Any other value (2'b01 E3, 2'b10 alternate framing, 2'b11 reserved) forces both words and `summary` to 0, while detection keeps running.
- R8: `summary` is 1 exactly when any reported status bit is 1.
- R9: `irq_n` is 0 exactly when `summary` is 1 and `irq_mask` is 1; otherwise it is 1.
- R10: A synchronous active-low reset clears all counters and status bits, giving both words 0, `summary` 0 and `irq_n` 1.
- R11: Each port's detector is independent of the frames seen on other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 28 | Per-port strobe, one cycle per received frame |
| c1 | input | 28 | Per-port first control bit |
| c2 | input | 28 | Per-port second control bit |
| c3 | input | 28 | Per-port third control bit |
| mode | input | 2 | Framing mode: 00 multiplex, 01 E3, 10 alternate, 11 reserved |
| irq_mask | input | 1 | Enables the summary onto the interrupt |
| stat_lo | output | 16 | Status of ports 0..15 |
| stat_hi | output | 16 | Status of ports 16..27 in bits 11:0, zero above |
| summary | output | 1 | OR of all reported status bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The persistence counters are hidden state. A wrong count appears at the ports as a status bit that changes one frame too early or too late, or as a bit that fails to restart after an interrupted run. Each test therefore samples the status word after every strobe of a run: after the fourth frame it must still show the old value, and after the fifth the new one. Because the words are combinational from the status registers, an error is visible in the same cycle as the faulty strobe edge. A wrong lane in the packing shows at once as a bit in the wrong word or position.

// File: rtl/cbit_lb_pkg.sv
// Package: shared mode encoding for the C-bit loopback detector bank.
// Assumes: a two-bit mode field; only MODE_MUX reports status.
package cbit_lb_pkg;
    typedef enum logic [1:0] {
        MODE_MUX = 2'b00,
        MODE_E3  = 2'b01,
        MODE_ALT = 2'b10,
        MODE_RSV = 2'b11
    } lb_mode_e;
endpackage

// File: rtl/cbit_port_det.sv
// Module: cbit_port_det
// One tributary's loopback command detector. It counts consecutive matching
// and non-matching frames, each count saturating at PERSIST, and moves the
// status on the frame that completes a run.
// Assumes: stb is high for one cycle per frame; c1..c3 are valid with stb.
module cbit_port_det #(
    parameter int PERSIST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic c1,
    input  logic c2,
    input  logic c3,
    output logic status
);
    localparam int CW = $clog2(PERSIST + 1);
    localparam logic [CW-1:0] FULL = CW'(PERSIST);
    localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

    logic          match;
    logic [CW-1:0] set_cnt;
    logic [CW-1:0] clr_cnt;

    // Command pattern: C1 and C2 agree and C3 is their complement.
    assign match = (c1 == c2) && (c3 != c1);

    // Persistence counters and status, advanced only on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_cnt <= '0;
            clr_cnt <= '0;
            status  <= 1'b0;
        end else if (stb) begin
            if (match) begin
                clr_cnt <= '0;
                if (set_cnt != FULL) set_cnt <= set_cnt + 1'b1;
                if (set_cnt >= LAST) status <= 1'b1;
            end else begin
                set_cnt <= '0;
                if (clr_cnt != FULL) clr_cnt <= clr_cnt + 1'b1;
                if (clr_cnt >= LAST) status <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cbit_status_pack.sv
// Module: cbit_status_pack
// Packs the per-port status vector into two words, blanks everything
// outside the multiplex mode, and forms the summary and interrupt.
// Assumes: NPORTS <= 2*WORD; unused upper bits read as zero.
module cbit_status_pack
    import cbit_lb_pkg::*;
#(
    parameter int NPORTS = 28,
    parameter int WORD   = 16
) (
    input  logic [NPORTS-1:0] st,
    input  logic [1:0]        mode,
    input  logic              irq_mask,
    output logic [WORD-1:0]   stat_lo,
    output logic [WORD-1:0]   stat_hi,
    output logic              summary,
    output logic              irq_n
);
    localparam int TOTAL = 2 * WORD;

    logic [TOTAL-1:0] wide;
    logic             report;

    // Only the multiplex mode gives the status a meaning.
    assign report = (lb_mode_e'(mode) == MODE_MUX);

    // Zero-extend the gated status into both words.
    always_comb begin
        wide = '0;
        wide[NPORTS-1:0] = report ? st : '0;
    end

    assign stat_lo = wide[WORD-1:0];
    assign stat_hi = wide[TOTAL-1:WORD];

    // Summary OR and the masked, active-low interrupt.
    assign summary = |wide;
    assign irq_n   = ~(summary & irq_mask);
endmodule

// File: rtl/cbit_lb_detect_bank.sv
// Module: cbit_lb_detect_bank (top)
// Bank of per-port loopback command detectors with packed status words,
// a summary bit and a maskable active-low interrupt.
// Assumes: synchronous active-low reset; one strobe per frame per port.
module cbit_lb_detect_bank #(
    parameter int NPORTS  = 28,
    parameter int WORD    = 16,
    parameter int PERSIST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] frame_stb,
    input  logic [NPORTS-1:0] c1,
    input  logic [NPORTS-1:0] c2,
    input  logic [NPORTS-1:0] c3,
    input  logic [1:0]        mode,
    input  logic              irq_mask,
    output logic [WORD-1:0]   stat_lo,
    output logic [WORD-1:0]   stat_hi,
    output logic              summary,
    output logic              irq_n
);
    logic [NPORTS-1:0] raw_st;

    // One detector per tributary port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        cbit_port_det #(.PERSIST(PERSIST)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (frame_stb[p]),
            .c1     (c1[p]),
            .c2     (c2[p]),
            .c3     (c3[p]),
            .status (raw_st[p])
        );
    end

    // Word packing, mode blanking and interrupt.
    cbit_status_pack #(.NPORTS(NPORTS), .WORD(WORD)) u_pack (
        .st       (raw_st),
        .mode     (mode),
        .irq_mask (irq_mask),
        .stat_lo  (stat_lo),
        .stat_hi  (stat_hi),
        .summary  (summary),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/cbit_lb_checker.sv
// Module: cbit_lb_checker
// Temporal checks on the detector bank, attached by bind below.
// Assumes: the same parameters as the bound top instance.
module cbit_lb_checker #(
    parameter int NPORTS = 28,
    parameter int WORD   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] frame_stb,
    input logic [NPORTS-1:0] c1,
    input logic [NPORTS-1:0] c2,
    input logic [NPORTS-1:0] c3,
    input logic [1:0]        mode,
    input logic              irq_mask,
    input logic [WORD-1:0]   stat_lo,
    input logic [WORD-1:0]   stat_hi,
    input logic              summary,
    input logic              irq_n,
    input logic [NPORTS-1:0] raw_st
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R5: without a strobe the port's status holds.
        a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_stb[p] |=> $stable(raw_st[p]));
        // R2: a rise needs a matching frame on the previous edge.
        a_r2_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_st[p]) |-> $past(frame_stb[p] && (c1[p] == c2[p]) && (c3[p] != c1[p])));
        // R4: a fall needs a non-matching frame on the previous edge.
        a_r4_fall_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(raw_st[p]) |-> $past(frame_stb[p] && !((c1[p] == c2[p]) && (c3[p] != c1[p]))));
    end

    // R6: the unused upper bits of the second word stay zero.
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hi[WORD-1:NPORTS-WORD] == '0);
    // R7: any mode other than multiplex blanks the reported status.
    a_r7_blank_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> (stat_lo == '0 && stat_hi == '0 && !summary));
    // R8: summary reflects the two words.
    a_r8_summary_or: assert property (@(posedge clk) disable iff (!rst_n)
        summary == ((|stat_lo) || (|stat_hi)));
    // R9: interrupt is low only for a masked-in summary.
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n == 1'b0) == (summary && irq_mask));
endmodule

bind cbit_lb_detect_bank cbit_lb_checker #(.NPORTS(NPORTS), .WORD(WORD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .c1        (c1),
    .c2        (c2),
    .c3        (c3),
    .mode      (mode),
    .irq_mask  (irq_mask),
    .stat_lo   (stat_lo),
    .stat_hi   (stat_hi),
    .summary   (summary),
    .irq_n     (irq_n),
    .raw_st    (raw_st)
);

// File: tb/tb_cbit_lb_detect_bank.sv
// Directed bench for cbit_lb_detect_bank: one task per scenario.
module tb_cbit_lb_detect_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 28;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] frame_stb = '0;
    logic [NP-1:0] c1 = '0, c2 = '0, c3 = '0;
    logic [1:0]    mode = 2'b00;
    logic          irq_mask = 1'b0;
    logic [15:0]   stat_lo, stat_hi;
    logic          summary, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cbit_lb_detect_bank dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .c1(c1), .c2(c2), .c3(c3), .mode(mode), .irq_mask(irq_mask),
        .stat_lo(stat_lo), .stat_hi(stat_hi), .summary(summary), .irq_n(irq_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] words();
        return {stat_hi, stat_lo};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_stb = '0; mode = 2'b00; irq_mask = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One frame on the selected ports with the given C-bits.
    task automatic frame(input logic [NP-1:0] ports, input logic a, input logic b, input logic c);
        @(negedge clk);
        frame_stb = ports;
        c1 = a ? ports : '0;
        c2 = b ? ports : '0;
        c3 = c ? ports : '0;
        @(negedge clk);
        frame_stb = '0;
    endtask

    task automatic frames(input logic [NP-1:0] ports, input int n,
                          input logic a, input logic b, input logic c);
        for (int i = 0; i < n; i++) frame(ports, a, b, c);
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 words", words(), 32'h0);
        check("R10 summary", {31'b0, summary}, 32'h0);
        check("R10 irq_n", {31'b0, irq_n}, 32'h1);
    endtask

    task automatic t_set_five();
        do_reset();
        irq_mask = 1'b1;
        frames(28'h1 << 3, 4, 1'b1, 1'b1, 1'b0);
        check("R2 four frames", words(), 32'h0);
        check("R9 irq idle", {31'b0, irq_n}, 32'h1);
        frame(28'h1 << 3, 1'b1, 1'b1, 1'b0);
        check("R2 fifth frame", words(), 32'h8);
        check("R8 summary", {31'b0, summary}, 32'h1);
        check("R9 irq asserted", {31'b0, irq_n}, 32'h0);
        irq_mask = 1'b0;
        #1 check("R9 masked", {31'b0, irq_n}, 32'h1);
    endtask

    task automatic t_patterns();
        do_reset();
        frames(28'h1 << 5, 5, 1'b0, 1'b0, 1'b1);
        check("R1 pattern 001", words(), 32'h20);
        frames(28'h1 << 6, 5, 1'b0, 1'b1, 1'b1);
        check("R1 c1!=c2 011", words(), 32'h20);
        frames(28'h1 << 6, 5, 1'b1, 1'b0, 1'b0);
        check("R1 c1!=c2 100", words(), 32'h20);
        frames(28'h1 << 6, 5, 1'b1, 1'b1, 1'b1);
        check("R1 no complement 111", words(), 32'h20);
    endtask

    task automatic t_broken_run();
        do_reset();
        frames(28'h1 << 7, 4, 1'b1, 1'b1, 1'b0);
        frame(28'h1 << 7, 1'b0, 1'b0, 1'b0);
        frames(28'h1 << 7, 4, 1'b1, 1'b1, 1'b0);
        check("R3 restarted run", words(), 32'h0);
        frame(28'h1 << 7, 1'b1, 1'b1, 1'b0);
        check("R3 completed run", words(), 32'h80);
    endtask

    task automatic t_clear();
        do_reset();
        frames(28'h4, 5, 1'b1, 1'b1, 1'b0);
        check("R4 set first", words(), 32'h4);
        frames(28'h4, 4, 1'b0, 1'b1, 1'b0);
        check("R4 four misses", words(), 32'h4);
        frame(28'h4, 1'b1, 1'b1, 1'b0);
        frames(28'h4, 4, 1'b1, 1'b1, 1'b1);
        check("R4 restarted release", words(), 32'h4);
        frame(28'h4, 1'b1, 1'b1, 1'b1);
        check("R4 fifth miss", words(), 32'h0);
    endtask

    task automatic t_no_strobe();
        do_reset();
        frames(28'h2, 4, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        c1 = '1; c2 = '1; c3 = '0;
        repeat (20) @(negedge clk);
        check("R5 idle matching bits", words(), 32'h0);
        frame(28'h2, 1'b1, 1'b1, 1'b0);
        check("R5 count kept", words(), 32'h2);
    endtask

    task automatic t_map();
        do_reset();
        frames((28'h1 << 15) | (28'h1 << 16) | (28'h1 << 27), 5, 1'b1, 1'b1, 1'b0);
        frames(28'h1, 5, 1'b1, 1'b0, 1'b0);
        check("R6 low word", {16'h0, stat_lo}, 32'h8000);
        check("R6 high word", {16'h0, stat_hi}, 32'h0801);
        check("R11 neighbour untouched", {31'b0, stat_lo[0]}, 32'h0);
    endtask

    task automatic t_mode();
        do_reset();
        irq_mask = 1'b1;
        frames((28'h1 << 9) | (28'h1 << 20), 5, 1'b1, 1'b1, 1'b0);
        mode = 2'b01;
        #1 check("R7 E3 blank", words(), 32'h0);
        check("R7 E3 summary", {30'b0, summary, irq_n}, 32'h1);
        mode = 2'b10;
        frames(28'h1 << 11, 5, 1'b0, 1'b0, 1'b1);
        check("R7 alt blank", words(), 32'h0);
        mode = 2'b00;
        #1 check("R7 detection continued", words(), 32'h0010_0A00);
        check("R8 summary back", {30'b0, summary, irq_n}, 32'h2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_set_five();
        t_patterns();
        t_broken_run();
        t_clear();
        t_no_strobe();
        t_map();
        t_mode();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule